// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block arbitrates twelve interrupt request flags for a small 8-bit processor core. It keeps the flag register, a per-source enable, a master enable and a 2-bit priority per source. On every machine-cycle strobe it looks at the flags that are both pending and enabled and picks one winner. It then decides whether the core may branch to that source's vector. The decision needs an instruction boundary and no conflicting instruction. It also needs an in-service stack that allows only strictly higher levels to preempt the one being handled.

When a branch is granted, the controller sends the core a one-cycle request with the source index and its vector address. It marks the winner's level as in service. It clears the winner's flag only for sources whose flag hardware is allowed to clear: timers, and external pins in edge mode. Serial, comparator, bus, brake and watchdog flags stay set until software clears them. Software can force any flag high or low to raise or withdraw a request. The two external pins are sampled on the strobe. Each pin is either falling-edge detected or followed as an active-low level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset the flags, the in-service bits, the enables, the master enable and `vec_req` are all zero.
- R2: A source competes only when its flag, its enable bit and the master enable are all 1. With the master enable at 0 no vector is ever requested. Configuration writes take effect at the clock edge where they are written.
- R3: Among competing sources the one with the largest 2-bit priority value wins (3 is the highest). On equal priority the lowest source index wins.
- R4: A grant happens only at an edge where `mc_en` and `instr_last` are 1 and `instr_cfg_wr` and `instr_reti` are 0.
- R5: A grant is refused while any in-service bit at or above the winner's level is set. A grant sets bit `win_level` of `insvc`, which allows nesting of strictly higher levels.
- R6: At an edge with `mc_en`, `instr_last` and `instr_reti` all 1, the highest set in-service bit is cleared.
- R7: A grant raises `vec_req` for exactly the following cycle, with `vec_src` = source index and `vec_addr` = 0x0003 + 8 × index. Both values hold until the next grant.
- R8: A grant clears the winner's flag only for sources 1 and 3 (timers), and for sources 0 and 2 (external pins) while those are in edge mode. All other flags are left set.
- R9: In edge mode (`ext_edge_mode[k]`=1), external pin k (`ext_n[k]` → flag 2k) sets its flag when it is sampled 1 on one strobe and 0 on the next strobe. Pin changes between strobes are not sampled.
- R10: In level mode (`ext_edge_mode[k]`=0), flag 2k takes the inverted pin value on every strobe.
- R11: A software write (`sw_flag_mask` bit = 1) puts `sw_flag_val` into that flag at the same edge. It overrides hardware set, pin sampling and grant clear.
- R12: A `hw_set` bit sets its flag at any clock edge, even without a strobe, and wins over the grant clear of the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle strobe: sampling and polling edge |
| instr_last | input | 1 | Current machine cycle ends the instruction |
| instr_cfg_wr | input | 1 | Current instruction writes an enable or priority register |
| instr_reti | input | 1 | Current instruction returns from interrupt |
| cfg_en_we | input | 1 | Write per-source enables |
| cfg_en_wdata | input | NUM_SRC | New per-source enables |
| cfg_ea_we | input | 1 | Write master enable |
| cfg_ea_wdata | input | 1 | New master enable |
| cfg_pri_we | input | 1 | Write priorities |
| cfg_pri_wdata | input | 2·NUM_SRC | Priority of source i in bits [2i+1:2i] |
| ext_edge_mode | input | 2 | Per external pin: 1 edge mode, 0 level mode |
| ext_n | input | 2 | Active-low external request pins |
| hw_set | input | NUM_SRC | Peripheral flag set pulses |
| sw_flag_mask | input | NUM_SRC | Software flag write select |
| sw_flag_val | input | NUM_SRC | Software flag write value |
| flags | output | NUM_SRC | Current request flags |
| insvc | output | NUM_LVL | In-service bit per priority level |
| vec_req | output | 1 | One-cycle vector call request |
| vec_src | output | 4 | Index of the granted source |
| vec_addr | output | ADDR_W | Vector address of the granted source |

## Verification
Three events can land on the same clock edge and change the same flag bit: a grant's hardware clear, a peripheral set pulse and a software write. A grant can also meet a return-from-interrupt or a configuration write in the same machine cycle. Directed sequences force each collision on purpose: a timer grant with a new set pulse, a software clear with a set pulse, and a strobe that carries the return marker. Constrained random cycles then mix all inputs freely. Every edge is judged against a bench model that applies the stated order of precedence, and the flags, in-service bits and vector outputs are compared after each edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_EXT = 2;

  // flag position driven by external pin k
  function automatic int unsigned ext_pos(input int unsigned k);
    return 2 * k;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mc_en,
  input  logic [NUM_EXT-1:0] ext_n,
  input  logic [NUM_EXT-1:0] ext_edge_mode,
  input  logic [NUM_SRC-1:0] hw_set,
  input  logic [NUM_SRC-1:0] hw_clr,
  input  logic [NUM_SRC-1:0] sw_mask,
  input  logic [NUM_SRC-1:0] sw_val,
  output logic [NUM_SRC-1:0] flags
);
  logic [NUM_EXT-1:0] pin_prev;
  logic [NUM_SRC-1:0] flags_nxt;

  // precedence: grant clear < peripheral set < pin sampling < software
  always_comb begin
    flags_nxt = (flags & ~hw_clr) | hw_set;
    for (int k = 0; k < NUM_EXT; k++) begin
      if (mc_en) begin
        if (ext_edge_mode[k]) begin
          if (pin_prev[k] && !ext_n[k]) flags_nxt[ext_pos(k)] = 1'b1;
        end else begin
          flags_nxt[ext_pos(k)] = !ext_n[k];
        end
      end
    end
    flags_nxt = (flags_nxt & ~sw_mask) | (sw_val & sw_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      pin_prev <= '1;
    end else begin
      flags <= flags_nxt;
      if (mc_en) pin_prev <= ext_n;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter  int unsigned NUM_SRC = 12,
  parameter  int unsigned NUM_LVL = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC),
  localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_SRC-1:0]       flags,
  input  logic [NUM_SRC-1:0]       en,
  input  logic                     ea,
  input  logic [NUM_SRC*LVL_W-1:0] pri,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  logic [NUM_SRC-1:0] req;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_req
    assign req[i] = flags[i] & en[i] & ea;
  end

  // strict compare while scanning upward keeps the lowest index on a tie
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!found || pri[i*LVL_W +: LVL_W] > win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = pri[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_insvc.sv
module irq_insvc #(
  parameter  int unsigned NUM_LVL = 4,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_lvl,
  input  logic               ret_en,
  output logic [NUM_LVL-1:0] insvc,
  output logic               busy,
  output logic [LVL_W-1:0]   top_lvl
);
  logic [NUM_LVL-1:0] insvc_nxt;

  always_comb begin
    busy    = |insvc;
    top_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (insvc[l]) top_lvl = LVL_W'(l);
    end
  end

  always_comb begin
    insvc_nxt = insvc;
    if (set_en)              insvc_nxt[set_lvl] = 1'b1;
    else if (ret_en && busy) insvc_nxt[top_lvl] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) insvc <= '0;
    else     insvc <= insvc_nxt;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter  int unsigned          NUM_SRC    = 12,
  parameter  int unsigned          NUM_LVL    = 4,
  parameter  int unsigned          ADDR_W     = 16,
  parameter  logic [ADDR_W-1:0]    VEC_BASE   = 'h0003,
  parameter  int unsigned          VEC_STEP   = 8,
  parameter  logic [NUM_SRC-1:0]   HWCLR_MASK = 'h00F,
  localparam int unsigned          IDX_W      = $clog2(NUM_SRC),
  localparam int unsigned          LVL_W      = $clog2(NUM_LVL)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mc_en,
  input  logic                     instr_last,
  input  logic                     instr_cfg_wr,
  input  logic                     instr_reti,
  input  logic                     cfg_en_we,
  input  logic [NUM_SRC-1:0]       cfg_en_wdata,
  input  logic                     cfg_ea_we,
  input  logic                     cfg_ea_wdata,
  input  logic                     cfg_pri_we,
  input  logic [NUM_SRC*LVL_W-1:0] cfg_pri_wdata,
  input  logic [NUM_EXT-1:0]       ext_edge_mode,
  input  logic [NUM_EXT-1:0]       ext_n,
  input  logic [NUM_SRC-1:0]       hw_set,
  input  logic [NUM_SRC-1:0]       sw_flag_mask,
  input  logic [NUM_SRC-1:0]       sw_flag_val,
  output logic [NUM_SRC-1:0]       flags,
  output logic [NUM_LVL-1:0]       insvc,
  output logic                     vec_req,
  output logic [IDX_W-1:0]         vec_src,
  output logic [ADDR_W-1:0]        vec_addr
);
  logic [NUM_SRC-1:0]       en_q;
  logic                     ea_q;
  logic [NUM_SRC*LVL_W-1:0] pri_q;

  logic                     found;
  logic [IDX_W-1:0]         win_idx;
  logic [LVL_W-1:0]         win_lvl;
  logic                     busy;
  logic [LVL_W-1:0]         top_lvl;
  logic                     blocked;
  logic                     grant;
  logic                     ret_take;
  logic [NUM_SRC-1:0]       hwclr_eff;
  logic [NUM_SRC-1:0]       clr_vec;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ea_q  <= 1'b0;
      pri_q <= '0;
    end else begin
      if (cfg_en_we)  en_q  <= cfg_en_wdata;
      if (cfg_ea_we)  ea_q  <= cfg_ea_wdata;
      if (cfg_pri_we) pri_q <= cfg_pri_wdata;
    end
  end

  irq_arbiter #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) arb_i (
    .flags   (flags),
    .en      (en_q),
    .ea      (ea_q),
    .pri     (pri_q),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  assign blocked  = busy && (top_lvl >= win_lvl);
  assign grant    = mc_en && instr_last && !instr_cfg_wr && !instr_reti
                    && found && !blocked;
  assign ret_take = mc_en && instr_last && instr_reti;

  // externals in level mode keep their flag on a grant
  always_comb begin
    hwclr_eff = HWCLR_MASK;
    for (int k = 0; k < NUM_EXT; k++) begin
      if (!ext_edge_mode[k]) hwclr_eff[ext_pos(k)] = 1'b0;
    end
    clr_vec = '0;
    if (grant) clr_vec[win_idx] = hwclr_eff[win_idx];
  end

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) flg_i (
    .clk           (clk),
    .rst           (rst),
    .mc_en         (mc_en),
    .ext_n         (ext_n),
    .ext_edge_mode (ext_edge_mode),
    .hw_set        (hw_set),
    .hw_clr        (clr_vec),
    .sw_mask       (sw_flag_mask),
    .sw_val        (sw_flag_val),
    .flags         (flags)
  );

  irq_insvc #(.NUM_LVL(NUM_LVL)) isv_i (
    .clk     (clk),
    .rst     (rst),
    .set_en  (grant),
    .set_lvl (win_lvl),
    .ret_en  (ret_take),
    .insvc   (insvc),
    .busy    (busy),
    .top_lvl (top_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_req  <= 1'b0;
      vec_src  <= '0;
      vec_addr <= '0;
    end else begin
      vec_req <= grant;
      if (grant) begin
        vec_src  <= win_idx;
        vec_addr <= VEC_BASE + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter  int unsigned       NUM_SRC  = 12,
  parameter  int unsigned       NUM_LVL  = 4,
  parameter  int unsigned       ADDR_W   = 16,
  parameter  logic [ADDR_W-1:0] VEC_BASE = 'h0003,
  parameter  int unsigned       VEC_STEP = 8,
  localparam int unsigned       IDX_W    = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               mc_en,
  input logic               instr_last,
  input logic               instr_cfg_wr,
  input logic               instr_reti,
  input logic               ea_q,
  input logic [1:0]         ext_edge_mode,
  input logic [1:0]         ext_n,
  input logic [NUM_SRC-1:0] sw_flag_mask,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_LVL-1:0] insvc,
  input logic               vec_req,
  input logic [IDX_W-1:0]   vec_src,
  input logic [ADDR_W-1:0]  vec_addr
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (flags == '0 && insvc == '0 && !vec_req));

  // R2
  master_enable_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> $past(ea_q));

  // R4
  grant_window_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> $past(mc_en && instr_last && !instr_cfg_wr && !instr_reti));

  // R5
  nest_push_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> ($countones(insvc) == $past($countones(insvc)) + 1));

  // R6
  nest_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_en && instr_last && instr_reti && insvc != '0)
      |=> ($countones(insvc) == $past($countones(insvc)) - 1));

  // R7
  vector_addr_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (vec_addr == VEC_BASE + ADDR_W'(vec_src) * ADDR_W'(VEC_STEP)));

  // R10
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_en && !ext_edge_mode[0] && !sw_flag_mask[0])
      |=> (flags[0] == !$past(ext_n[0])));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC  (NUM_SRC),
  .NUM_LVL  (NUM_LVL),
  .ADDR_W   (ADDR_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .mc_en         (mc_en),
  .instr_last    (instr_last),
  .instr_cfg_wr  (instr_cfg_wr),
  .instr_reti    (instr_reti),
  .ea_q          (ea_q),
  .ext_edge_mode (ext_edge_mode),
  .ext_n         (ext_n),
  .sw_flag_mask  (sw_flag_mask),
  .flags         (flags),
  .insvc         (insvc),
  .vec_req       (vec_req),
  .vec_src       (vec_src),
  .vec_addr      (vec_addr)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mc_en = 0, instr_last = 0, instr_cfg_wr = 0, instr_reti = 0;
  logic        cfg_en_we = 0, cfg_ea_we = 0, cfg_ea_wdata = 0, cfg_pri_we = 0;
  logic [11:0] cfg_en_wdata = '0;
  logic [23:0] cfg_pri_wdata = '0;
  logic [1:0]  ext_edge_mode = 2'b11, ext_n = 2'b11;
  logic [11:0] hw_set = '0, sw_flag_mask = '0, sw_flag_val = '0;
  logic [11:0] flags;
  logic [3:0]  insvc;
  logic        vec_req;
  logic [3:0]  vec_src;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model state
  logic [11:0] m_flags, m_en;
  logic        m_ea;
  logic [23:0] m_pri;
  logic [3:0]  m_ins;
  logic [1:0]  m_prev;
  logic        exp_req;
  int          exp_src, exp_addr;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .mc_en(mc_en), .instr_last(instr_last),
    .instr_cfg_wr(instr_cfg_wr), .instr_reti(instr_reti),
    .cfg_en_we(cfg_en_we), .cfg_en_wdata(cfg_en_wdata),
    .cfg_ea_we(cfg_ea_we), .cfg_ea_wdata(cfg_ea_wdata),
    .cfg_pri_we(cfg_pri_we), .cfg_pri_wdata(cfg_pri_wdata),
    .ext_edge_mode(ext_edge_mode), .ext_n(ext_n), .hw_set(hw_set),
    .sw_flag_mask(sw_flag_mask), .sw_flag_val(sw_flag_val),
    .flags(flags), .insvc(insvc), .vec_req(vec_req),
    .vec_src(vec_src), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input string what, input int unsigned act,
                     input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit hw_clears(input int idx);
    return idx == 1 || idx == 3 || (idx == 0 && ext_edge_mode[0]) ||
           (idx == 2 && ext_edge_mode[1]);
  endfunction

  task automatic model_reset();
    m_flags = '0; m_en = '0; m_ea = 0; m_pri = '0; m_ins = '0; m_prev = 2'b11;
    exp_req = 0; exp_src = 0; exp_addr = 0;
  endtask

  task automatic model_step();
    bit found = 0;
    int bi = 0, bl = 0, top = -1;
    bit disp, ret;
    logic [11:0] nf;
    for (int i = 0; i < 12; i++) begin
      if (m_flags[i] && m_en[i] && m_ea) begin
        int p = int'(m_pri[2*i +: 2]);
        if (!found || p > bl) begin found = 1; bi = i; bl = p; end
      end
    end
    for (int l = 0; l < 4; l++) if (m_ins[l]) top = l;
    disp = mc_en && instr_last && !instr_cfg_wr && !instr_reti && found && (top < bl);
    ret  = mc_en && instr_last && instr_reti;
    nf = m_flags;
    if (disp && hw_clears(bi)) nf[bi] = 1'b0;
    nf |= hw_set;
    if (mc_en) begin
      for (int k = 0; k < 2; k++) begin
        if (ext_edge_mode[k]) begin
          if (m_prev[k] && !ext_n[k]) nf[2*k] = 1'b1;
        end else nf[2*k] = !ext_n[k];
      end
      m_prev = ext_n;
    end
    nf = (nf & ~sw_flag_mask) | (sw_flag_val & sw_flag_mask);
    m_flags = nf;
    if (disp) m_ins[bl] = 1'b1;
    else if (ret && top >= 0) m_ins[top] = 1'b0;
    exp_req = disp;
    if (disp) begin exp_src = bi; exp_addr = 3 + 8 * bi; end
    if (cfg_en_we)  m_en  = cfg_en_wdata;
    if (cfg_ea_we)  m_ea  = cfg_ea_wdata;
    if (cfg_pri_we) m_pri = cfg_pri_wdata;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R11", "flags", flags, m_flags);
    chk("R5", "insvc", insvc, m_ins);
    chk("R4", "vec_req", vec_req, exp_req);
    if (exp_req) begin
      chk("R7", "vec_src", vec_src, exp_src);
      chk("R7", "vec_addr", vec_addr, exp_addr);
    end
  endtask

  task automatic idle();
    mc_en = 0; instr_last = 0; instr_cfg_wr = 0; instr_reti = 0;
    cfg_en_we = 0; cfg_ea_we = 0; cfg_pri_we = 0;
    hw_set = '0; sw_flag_mask = '0; sw_flag_val = '0;
  endtask

  task automatic swflag(input logic [11:0] mask, input logic [11:0] val);
    idle(); sw_flag_mask = mask; sw_flag_val = val; tick();
  endtask

  task automatic strobe(input bit last, input bit cw, input bit rt);
    idle(); mc_en = 1; instr_last = last; instr_cfg_wr = cw; instr_reti = rt; tick();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    // R1 reset state
    chk("R1", "flags", flags, 0);
    chk("R1", "insvc", insvc, 0);
    chk("R1", "vec_req", vec_req, 0);

    // R2 masking by enables
    idle(); sw_flag_mask = 12'h020; sw_flag_val = 12'h020;
    cfg_en_we = 1; cfg_en_wdata = 12'hFFF; tick();
    strobe(1, 0, 0);
    chk("R2", "vec_req with master off", vec_req, 0);
    idle(); cfg_ea_we = 1; cfg_ea_wdata = 1; tick();
    strobe(1, 0, 0);
    chk("R2", "vec_req", vec_req, 1);
    chk("R7", "vec_addr src5", vec_addr, 16'h002B);
    chk("R5", "insvc level0", insvc, 4'b0001);
    chk("R8", "serial flag kept", flags[5], 1);
    strobe(1, 0, 1);
    chk("R6", "insvc after return", insvc, 0);
    chk("R4", "no grant on return", vec_req, 0);
    swflag(12'hFFF, 12'h000);

    // R3 priority and tie break, R5 nesting
    idle(); cfg_pri_we = 1;
    cfg_pri_wdata = (24'd2 << 18) | (24'd2 << 12) | (24'd1 << 8) | (24'd3 << 20);
    sw_flag_mask = 12'h250; sw_flag_val = 12'h250; tick();
    strobe(1, 0, 0);
    chk("R3", "tie winner", vec_src, 6);
    chk("R7", "vec_addr src6", vec_addr, 16'h0033);
    chk("R5", "insvc level2", insvc, 4'b0100);
    strobe(1, 0, 0);
    chk("R5", "blocked at same level", vec_req, 0);
    swflag(12'h400, 12'h400);
    strobe(1, 0, 0);
    chk("R3", "higher level preempts", vec_src, 10);
    chk("R5", "nested insvc", insvc, 4'b1100);
    strobe(1, 0, 1);
    chk("R6", "top level popped", insvc, 4'b0100);
    strobe(1, 0, 1);
    chk("R6", "all popped", insvc, 0);
    idle(); cfg_pri_we = 1; cfg_pri_wdata = '0; sw_flag_mask = 12'hFFF; tick();

    // R4 instruction boundary and config write hold
    swflag(12'h080, 12'h080);
    strobe(0, 0, 0);
    chk("R4", "mid instruction", vec_req, 0);
    strobe(1, 1, 0);
    chk("R4", "config write", vec_req, 0);
    idle(); instr_last = 1; tick();
    chk("R4", "no strobe", vec_req, 0);
    strobe(1, 0, 0);
    chk("R4", "granted", vec_src, 7);
    strobe(1, 0, 1);
    swflag(12'hFFF, 12'h000);

    // R8 timer flag cleared by grant
    idle(); hw_set = 12'h002; tick();
    strobe(1, 0, 0);
    chk("R7", "timer vector", vec_addr, 16'h000B);
    chk("R8", "timer flag cleared", flags[1], 0);
    strobe(1, 0, 1);

    // R9 edge mode on pin 0
    idle(); ext_n = 2'b10; tick();
    chk("R9", "no sample off strobe", flags[0], 0);
    strobe(0, 0, 0);
    chk("R9", "edge captured", flags[0], 1);
    strobe(1, 0, 0);
    chk("R7", "ext0 vector", vec_addr, 16'h0003);
    chk("R8", "edge flag cleared", flags[0], 0);
    strobe(0, 0, 0);
    chk("R9", "held low no new edge", flags[0], 0);
    ext_n = 2'b11;
    strobe(1, 0, 1);

    // R10 level mode on pin 1 (flag 2)
    ext_edge_mode = 2'b01; ext_n = 2'b01;
    strobe(0, 0, 0);
    chk("R10", "level low", flags[2], 1);
    strobe(1, 0, 0);
    chk("R7", "ext1 vector", vec_addr, 16'h0013);
    chk("R8", "level flag kept", flags[2], 1);
    ext_n = 2'b11;
    strobe(0, 0, 0);
    chk("R10", "level high", flags[2], 0);
    strobe(1, 0, 1);
    ext_edge_mode = 2'b11;

    // R12 set beats grant clear, R11 software beats set
    idle(); hw_set = 12'h002; tick();
    idle(); mc_en = 1; instr_last = 1; hw_set = 12'h002; tick();
    chk("R12", "granted", vec_req, 1);
    chk("R12", "flag kept by set", flags[1], 1);
    strobe(1, 0, 1);
    idle(); hw_set = 12'h002; sw_flag_mask = 12'h002; sw_flag_val = 12'h000; tick();
    chk("R11", "software clear wins", flags[1], 0);

    // constrained random phase
    ext_edge_mode = 2'($urandom);
    for (int n = 0; n < 4000; n++) begin
      idle();
      mc_en        = ($urandom % 4) != 0;
      instr_last   = $urandom % 2;
      instr_cfg_wr = ($urandom % 10) == 0;
      instr_reti   = ($urandom % 6) == 0;
      hw_set       = 12'($urandom) & 12'($urandom) & 12'($urandom);
      if ($urandom % 8 == 0) ext_n = 2'($urandom);
      if ($urandom % 10 == 0) begin
        sw_flag_mask = 12'($urandom); sw_flag_val = 12'($urandom);
      end
      if ($urandom % 20 == 0) begin cfg_en_we = 1; cfg_en_wdata = 12'($urandom); end
      if ($urandom % 25 == 0) begin cfg_ea_we = 1; cfg_ea_wdata = ($urandom % 4) != 0; end
      if ($urandom % 20 == 0) begin cfg_pri_we = 1; cfg_pri_wdata = 24'($urandom); end
      if ($urandom % 300 == 0) ext_edge_mode = 2'($urandom);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule